// File: doc/BRIEF.md
# ALU Status Flag Generator

This block turns the result of an arithmetic or logic step into registered status flags, and it holds three control flags that software sets or clears. The ALU itself sits outside the block. For each operation the ALU supplies both operands, its raw result, the carry out of the most significant bit of the active operand size, an operation class and a byte/word select. A write enable marks the cycle in which the conditional flags take the new values. One clock edge later the six conditional flags appear on their outputs and stay there until the next write.

The six conditional flags are carry, nibble (auxiliary) carry, parity, zero, sign and overflow. Sign and overflow follow the selected operand size. Zero covers the active width only. Parity and the nibble carry always come from the low byte of the result. The three control flags are trap, interrupt enable and string direction. They ignore the write enable and change only on their own set and clear strobes. While the interrupt-enable flag is set, maskable interrupts are accepted. While the direction flag is set, string addresses count down; while it is clear, they count up.

Top module: `alu_flags`

## Requirements
- R1: An active-low asynchronous reset clears all nine flag outputs.
- R2: Conditional flags change only on a rising edge with wr_en_i high, and control flags change only on an edge with one of their strobes high; otherwise every output holds its value.
- R3: Carry: op_class_i 2'b00 (add) loads carry_i, 2'b01 (subtract, adder computes a + ~b + 1) loads the inverse of carry_i as a borrow, and 2'b10 (logic) clears it.
- R4: Nibble carry: for add and subtract it is set when a carry or borrow crosses from bit 3 into bit 4, which equals opa_i[4] ^ opb_i[4] ^ res_i[4]; a logic operation leaves it unchanged.
- R5: Parity is set when res_i[7:0] holds an even number of ones and cleared when the count is odd, for both sizes.
- R6: Zero is set when the active part of the result is all zeros (res_i[7:0] with word_i low, res_i[15:0] with word_i high) and cleared otherwise.
- R7: Sign copies res_i[15] when word_i is high and res_i[7] when word_i is low.
- R8: Overflow reports signed overflow of the active size: for add, the operands have equal signs and the result sign differs; for subtract, the operand signs differ and the result sign differs from opa_i; a logic operation clears it.
- R9: op_class_i 2'b11 is reserved, and a write with it leaves all six conditional flags unchanged.
- R10: Each control flag is set by its set strobe and cleared by its clear strobe, with clear winning when both are high, independent of wr_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Load conditional flags this cycle |
| op_class_i | input | 2 | 00 add, 01 subtract, 10 logic, 11 reserved |
| word_i | input | 1 | 1 selects 16-bit operands, 0 selects 8-bit |
| opa_i | input | 16 | First operand (minuend for subtract) |
| opb_i | input | 16 | Second operand (subtrahend for subtract) |
| res_i | input | 16 | Raw ALU result |
| carry_i | input | 1 | Adder carry out of the active MSB |
| tf_set_i | input | 1 | Set trap flag |
| tf_clr_i | input | 1 | Clear trap flag |
| if_set_i | input | 1 | Set interrupt-enable flag |
| if_clr_i | input | 1 | Clear interrupt-enable flag |
| df_set_i | input | 1 | Set direction flag |
| df_clr_i | input | 1 | Clear direction flag |
| cf_o | output | 1 | Carry / borrow flag |
| af_o | output | 1 | Nibble carry flag |
| pf_o | output | 1 | Parity flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |
| tf_o | output | 1 | Trap flag |
| if_o | output | 1 | Interrupt-enable flag |
| df_o | output | 1 | Direction flag (1 = decrement) |

## Verification
Every flag is a single register that one write reloads, so a wrong value is visible on the port one cycle after the write that caused it. It then persists until the next write, or until the next strobe for a control flag. The nibble-carry flag is the exception to full reload. A corrupted value survives any run of logic operations, so the checks pair logic writes with a known earlier nibble carry. Size-selection mistakes only show with operands whose upper byte disagrees with the low byte, so the stimulus places nonzero upper bytes under byte operations.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned CTRL_N = 3;

  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_SUB   = 2'b01,
    OP_LOGIC = 2'b10,
    OP_RSVD  = 2'b11
  } op_class_e;

  typedef struct packed {
    logic cf;
    logic af;
    logic pf;
    logic zf;
    logic sf;
    logic ovf;
  } cond_flags_t;

  typedef enum int unsigned {
    CTL_TRAP = 0,
    CTL_IEN  = 1,
    CTL_DIR  = 2
  } ctrl_idx_e;
endpackage

// File: rtl/afl_size_view.sv
module afl_size_view
  import alu_flags_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              word_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  output logic              sign_a_o,
  output logic              sign_b_o,
  output logic              sign_r_o,
  output logic              zero_o,
  output logic              par_even_o,
  output logic              nib_x_o
);
  localparam int unsigned MSB_W = DATA_W - 1;
  localparam int unsigned MSB_B = BYTE_W - 1;

  logic unused_ops;
  assign unused_ops = ^{opa_i, opb_i};

  assign sign_a_o   = word_i ? opa_i[MSB_W] : opa_i[MSB_B];
  assign sign_b_o   = word_i ? opb_i[MSB_W] : opb_i[MSB_B];
  assign sign_r_o   = word_i ? res_i[MSB_W] : res_i[MSB_B];
  assign zero_o     = word_i ? ~|res_i : ~|res_i[MSB_B:0];
  assign par_even_o = ~^res_i[MSB_B:0];
  // sum bit 4 xor both operand bits 4 = carry (or borrow) into bit 4
  assign nib_x_o    = opa_i[NIB_W] ^ opb_i[NIB_W] ^ res_i[NIB_W];
endmodule

// File: rtl/afl_arith_calc.sv
module afl_arith_calc
  import alu_flags_pkg::*;
(
  input  op_class_e op_i,
  input  logic      carry_i,
  input  logic      sign_a_i,
  input  logic      sign_b_i,
  input  logic      sign_r_i,
  input  logic      nib_x_i,
  output logic      cf_o,
  output logic      af_o,
  output logic      ovf_o,
  output logic      af_upd_o,
  output logic      cond_upd_o
);
  always_comb begin
    cf_o       = 1'b0;
    ovf_o      = 1'b0;
    af_o       = nib_x_i;
    af_upd_o   = 1'b0;
    cond_upd_o = 1'b1;
    unique case (op_i)
      OP_ADD: begin
        cf_o     = carry_i;
        ovf_o    = (sign_a_i == sign_b_i) && (sign_r_i != sign_a_i);
        af_upd_o = 1'b1;
      end
      OP_SUB: begin
        cf_o     = ~carry_i;
        ovf_o    = (sign_a_i != sign_b_i) && (sign_r_i != sign_a_i);
        af_upd_o = 1'b1;
      end
      OP_LOGIC: ;
      default: cond_upd_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/afl_ctrl_bit.sv
module afl_ctrl_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_flags_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        op_class_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              tf_set_i,
  input  logic              tf_clr_i,
  input  logic              if_set_i,
  input  logic              if_clr_i,
  input  logic              df_set_i,
  input  logic              df_clr_i,
  output logic              cf_o,
  output logic              af_o,
  output logic              pf_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o,
  output logic              tf_o,
  output logic              if_o,
  output logic              df_o
);
  op_class_e   op;
  logic        sign_a, sign_b, sign_r, zero, par_even, nib_x;
  logic        cf_n, af_n, ovf_n, af_upd, cond_upd;
  cond_flags_t cond_q;
  logic [CTRL_N-1:0] ctl_set, ctl_clr, ctl_q;

  assign op = op_class_e'(op_class_i);

  afl_size_view #(.DATA_W(DATA_W)) u_view (
    .word_i    (word_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .res_i     (res_i),
    .sign_a_o  (sign_a),
    .sign_b_o  (sign_b),
    .sign_r_o  (sign_r),
    .zero_o    (zero),
    .par_even_o(par_even),
    .nib_x_o   (nib_x)
  );

  afl_arith_calc u_arith (
    .op_i      (op),
    .carry_i   (carry_i),
    .sign_a_i  (sign_a),
    .sign_b_i  (sign_b),
    .sign_r_i  (sign_r),
    .nib_x_i   (nib_x),
    .cf_o      (cf_n),
    .af_o      (af_n),
    .ovf_o     (ovf_n),
    .af_upd_o  (af_upd),
    .cond_upd_o(cond_upd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= '0;
    end else if (wr_en_i && cond_upd) begin
      cond_q.cf  <= cf_n;
      cond_q.pf  <= par_even;
      cond_q.zf  <= zero;
      cond_q.sf  <= sign_r;
      cond_q.ovf <= ovf_n;
      if (af_upd) cond_q.af <= af_n;
    end
  end

  assign ctl_set[CTL_TRAP] = tf_set_i;
  assign ctl_clr[CTL_TRAP] = tf_clr_i;
  assign ctl_set[CTL_IEN]  = if_set_i;
  assign ctl_clr[CTL_IEN]  = if_clr_i;
  assign ctl_set[CTL_DIR]  = df_set_i;
  assign ctl_clr[CTL_DIR]  = df_clr_i;

  for (genvar g = 0; g < CTRL_N; g++) begin : g_ctrl
    afl_ctrl_bit u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (ctl_set[g]),
      .clr_i (ctl_clr[g]),
      .q_o   (ctl_q[g])
    );
  end

  assign cf_o = cond_q.cf;
  assign af_o = cond_q.af;
  assign pf_o = cond_q.pf;
  assign zf_o = cond_q.zf;
  assign sf_o = cond_q.sf;
  assign of_o = cond_q.ovf;
  assign tf_o = ctl_q[CTL_TRAP];
  assign if_o = ctl_q[CTL_IEN];
  assign df_o = ctl_q[CTL_DIR];
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  op_class_i,
  input logic        word_i,
  input logic [15:0] opa_i,
  input logic [15:0] opb_i,
  input logic [15:0] res_i,
  input logic        carry_i,
  input logic        tf_set_i,
  input logic        tf_clr_i,
  input logic        if_set_i,
  input logic        if_clr_i,
  input logic        df_set_i,
  input logic        df_clr_i,
  input logic        cf_o,
  input logic        af_o,
  input logic        pf_o,
  input logic        zf_o,
  input logic        sf_o,
  input logic        of_o,
  input logic        tf_o,
  input logic        if_o,
  input logic        df_o
);
  logic [5:0] cond;
  logic [2:0] ctl;
  logic       act;
  assign cond = {cf_o, af_o, pf_o, zf_o, sf_o, of_o};
  assign ctl  = {tf_o, if_o, df_o};
  assign act  = wr_en_i && (op_class_i != 2'b11);

  AST_CF_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && op_class_i == 2'b00 |=> cf_o == $past(carry_i)); // R3
  AST_CF_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && op_class_i == 2'b01 |=> cf_o == !$past(carry_i)); // R3
  AST_LOGIC_AF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && op_class_i == 2'b10 |=> af_o == $past(af_o)); // R4
  AST_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |=> pf_o == ~^$past(res_i[7:0])); // R5
  AST_ZERO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && word_i && res_i == 16'h0 |=> zf_o); // R6
  AST_SIGN_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && !word_i |=> sf_o == $past(res_i[7])); // R7
  AST_OVF_ADD_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && op_class_i == 2'b00 && word_i && opa_i[15] == opb_i[15] && res_i[15] != opa_i[15] |=> of_o); // R8
  AST_LOGIC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && op_class_i == 2'b10 |=> !cf_o && !of_o); // R8
  AST_RSVD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && op_class_i == 2'b11 |=> $stable(cond)); // R9
  AST_COND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cond)); // R2
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tf_set_i || tf_clr_i || if_set_i || if_clr_i || df_set_i || df_clr_i) |=> $stable(ctl)); // R2
  AST_IF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_set_i && !if_clr_i |=> if_o); // R10
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf_clr_i || if_clr_i || df_clr_i |=> !((tf_o && $past(tf_clr_i)) || (if_o && $past(if_clr_i)) || (df_o && $past(df_clr_i)))); // R10
endmodule

bind alu_flags alu_flags_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .op_class_i(op_class_i),
  .word_i(word_i), .opa_i(opa_i), .opb_i(opb_i), .res_i(res_i), .carry_i(carry_i),
  .tf_set_i(tf_set_i), .tf_clr_i(tf_clr_i), .if_set_i(if_set_i), .if_clr_i(if_clr_i),
  .df_set_i(df_set_i), .df_clr_i(df_clr_i), .cf_o(cf_o), .af_o(af_o), .pf_o(pf_o),
  .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o), .tf_o(tf_o), .if_o(if_o), .df_o(df_o)
);

// File: tb/alu_flags_tb_top.sv
module alu_flags_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0, word = 1'b0, carry = 1'b0;
  logic [1:0] op = 2'b00;
  logic [15:0] opa = '0, opb = '0, res = '0;
  logic [5:0] stb = '0; // {tf_set, tf_clr, if_set, if_clr, df_set, df_clr}
  logic cf, af, pf, zf, sf, ovf, tf, ien, dir;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [8:0] mdl = '0; // {cf,af,pf,zf,sf,of,tf,if,df}
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  alu_flags dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .op_class_i(op), .word_i(word),
    .opa_i(opa), .opb_i(opb), .res_i(res), .carry_i(carry),
    .tf_set_i(stb[5]), .tf_clr_i(stb[4]), .if_set_i(stb[3]), .if_clr_i(stb[2]),
    .df_set_i(stb[1]), .df_clr_i(stb[0]),
    .cf_o(cf), .af_o(af), .pf_o(pf), .zf_o(zf), .sf_o(sf), .of_o(ovf),
    .tf_o(tf), .if_o(ien), .df_o(dir)
  );

  function automatic logic [8:0] flags_now();
    return {cf, af, pf, zf, sf, ovf, tf, ien, dir};
  endfunction

  task automatic check_now(input logic [8:0] e, input string t);
    checks++;
    if (flags_now() !== e) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", t, flags_now(), e);
    end
  endtask

  task automatic step(input logic w_en, input logic [1:0] o, input logic w,
                      input logic [15:0] a, input logic [15:0] b,
                      input logic [5:0] s, input string t);
    int mask, as, bs, full, sa, sb, sv, smax, smin;
    logic [15:0] r;
    logic c;
    @(negedge clk);
    mask = w ? 32'hFFFF : 32'hFF;
    as = int'(a) & mask;
    bs = int'(b) & mask;
    if (o == 2'b00) begin
      full = as + bs; r = a + b;
    end else if (o == 2'b01) begin
      full = as + ((~bs) & mask) + 1; r = a - b;
    end else begin
      full = (as ^ mask) << 1; r = a & b;
    end
    c = w ? full[16] : full[8];
    wr_en = w_en; op = o; word = w; opa = a; opb = b; res = r; carry = c; stb = s;
    if (w_en && o != 2'b11) begin
      mdl[6] = ~^r[7:0];
      mdl[5] = (int'(r) & mask) == 0;
      mdl[4] = w ? r[15] : r[7];
      if (o == 2'b10) begin
        mdl[8] = 1'b0; mdl[3] = 1'b0;
      end else begin
        sa = w ? int'($signed(a)) : int'($signed(a[7:0]));
        sb = w ? int'($signed(b)) : int'($signed(b[7:0]));
        smax = w ? 32767 : 127;
        smin = w ? -32768 : -128;
        sv = (o == 2'b00) ? sa + sb : sa - sb;
        mdl[3] = (sv > smax) || (sv < smin);
        mdl[8] = (o == 2'b00) ? (as + bs > mask) : (as < bs);
        mdl[7] = (o == 2'b00) ? (int'(a[3:0]) + int'(b[3:0]) > 15) : (a[3:0] < b[3:0]);
      end
    end
    if (s[4]) mdl[2] = 1'b0; else if (s[5]) mdl[2] = 1'b1;
    if (s[2]) mdl[1] = 1'b0; else if (s[3]) mdl[1] = 1'b1;
    if (s[0]) mdl[0] = 1'b0; else if (s[1]) mdl[0] = 1'b1;
    exp_q.push_back(mdl);
    tag_q.push_back(t);
  endtask

  // monitor: compare each driven cycle just after the edge that registers it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check_now(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] x;
    x = 16'h1D2B;
    #5 check_now(9'b0, "R1 reset state");
    @(negedge clk) rst_ni = 1'b1;
    step(1, 2'b00, 0, 16'h0A7F, 16'h3301, 6'b0, "R4 R7 R8 byte add signed overflow");
    step(1, 2'b00, 0, 16'h12FF, 16'h0001, 6'b0, "R3 R6 byte add carry to zero");
    step(1, 2'b01, 1, 16'h0000, 16'h0001, 6'b0, "R3 R4 word sub borrow");
    step(1, 2'b01, 1, 16'h8000, 16'h0001, 6'b0, "R8 R7 word sub signed overflow");
    step(1, 2'b00, 0, 16'h1200, 16'h3400, 6'b0, "R6 byte zero with upper bits set");
    step(1, 2'b00, 1, 16'h0108, 16'h0008, 6'b0, "R4 R5 word add nibble carry");
    step(1, 2'b10, 1, 16'hF0F3, 16'h8F31, 6'b0, "R3 R4 R8 logic clears cf of, keeps af");
    step(1, 2'b01, 0, 16'h0010, 16'h0001, 6'b0, "R4 byte sub nibble borrow");
    step(1, 2'b10, 0, 16'h00FF, 16'h0003, 6'b0, "R4 R5 logic keeps af, parity even");
    step(1, 2'b11, 1, 16'h7FFF, 16'h0001, 6'b0, "R9 reserved op holds");
    step(0, 2'b00, 1, 16'hFFFF, 16'hFFFF, 6'b0, "R2 no write holds");
    step(0, 2'b00, 0, 16'h0000, 16'h0000, 6'b101010, "R10 set all control flags");
    step(0, 2'b00, 0, 16'h0000, 16'h0000, 6'b000100, "R10 clear interrupt enable");
    step(1, 2'b00, 1, 16'h4000, 16'h4000, 6'b000011, "R10 clear wins on direction");
    step(0, 2'b00, 0, 16'h0000, 16'h0000, 6'b0, "R2 control flags hold");
    for (int i = 0; i < 48; i++) begin
      logic [15:0] y;
      y = {x[7:0], x[15:8]} ^ 16'h5A3C;
      step(1, 2'(i % 3), i[2], x, y, 6'(i[1:0] == 2'b11 ? 6'b010000 : 6'b0),
           "R3 R4 R5 R6 R7 R8 sweep");
      x = x * 16'd25173 + 16'd13849;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    stb = 6'b101010;
    @(negedge clk);
    stb = '0;
    rst_ni = 1'b0;
    mdl = '0;
    #1 check_now(9'b0, "R1 asynchronous reset mid-run");
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule